// File: doc/BRIEF.md
# Double-Banked Correlation Dump Buffer

This block stores correlator results at the end of every integration period. A dump strobe opens a short window. In that window the correlator bank delivers its results one at a time, in ascending correlator order, each with its index. Every result goes into the bank that is being filled. Its location is chosen by the current integration-period count and the correlator index. Once a full frame of integration periods is stored, the filled bank is handed to the host and the other bank starts filling.

The host reads the bank it owns through a registered read port, one word per address. When it has finished with the frame, it raises a release pulse. If a frame is handed over before the previous one was released, the handover is flagged as an overrun. The bank roles change only at frame boundaries, so a host read never sees a half-written frame.

The default parameters keep the buffer small: 16 correlators and 16 integration periods per frame. The full-size instance sets `IDX_W = 7` and `CYC_W = 8`, which gives 128 correlators, 256 periods and 32768 sixteen-bit words per bank, with no change to the logic.

Top module: `corr_dump_buffer`

## Requirements
- R1: While reset is held, and in the cycle after it, `frame_ready_o` and `overrun_o` are 0 and `rd_bank_o` is 1. Bank 0 is the bank being filled, and the period count starts at 0.
- R2: An accepted result is stored at word address `{period_count, res_idx_i}` of the fill bank, with the period count in the upper `CYC_W` bits. After the swap, the host reads that word at the same address.
- R3: A result beat (`res_valid_i` = 1) is ignored when no dump window is open, even if its index is the last one. It writes nothing and does not advance the period count. A dump strobe that arrives while a window is open is also ignored. A beat in the same cycle as the strobe that opens the window is ignored too.
- R4: A dump window opens in the cycle after `dump_i`. It closes on the accepted beat whose index is all ones, and that beat increments the period count. Periods that are not the last in the frame raise no frame pulse.
- R5: On the accepted last beat of the last period, the banks swap at that same clock edge. `frame_ready_o` is 1 for exactly the next cycle, and `rd_bank_o` inverts at that edge.
- R6: `rd_data_o` returns the word at `rd_addr_i` in the host bank. The word appears one cycle after the address is sampled. Writes to the fill bank never disturb it.
- R7: `overrun_o` pulses together with `frame_ready_o` when the frame handed over at the previous swap has not been released. A frame counts as released when `rd_done_i` is sampled high at some clock edge after that swap. The first swap after reset never reports an overrun.
- R8: `rd_bank_o` changes only in the cycle in which `frame_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dump_i | input | 1 | End-of-integration strobe that opens a dump window |
| res_valid_i | input | 1 | Correlator result beat is present |
| res_idx_i | input | IDX_W | Correlator index of the beat |
| res_data_i | input | DATA_W | Correlator result value |
| rd_addr_i | input | CYC_W+IDX_W | Host read word address `{period, correlator}` |
| rd_done_i | input | 1 | Host has finished with the current frame |
| rd_data_o | output | DATA_W | Host read data, one cycle after the address |
| frame_ready_o | output | 1 | One-cycle pulse: a new frame belongs to the host |
| rd_bank_o | output | 1 | Index of the bank the host reads |
| overrun_o | output | 1 | One-cycle pulse with the frame pulse: previous frame was not released |

## Verification
Timing of each result:
- **Stored result.** It lands at the clock edge that samples its beat. It can be read only after the swap.
- **Read data.** The bench drives an address half a cycle before an edge. It compares `rd_data_o` at the next falling edge, one full cycle later.
- **Frame handover.** The last accepted beat of a frame is sampled at one edge. `frame_ready_o`, `overrun_o` and the new `rd_bank_o` are due right after that edge. The bench checks them at the falling edge that follows the beat, and checks one cycle later that the pulse has dropped.
- **Stray beats.** These take effect only through the period count. Their absence of effect shows up at the port as no early frame pulse at the end of each non-final period, and as intact data when the frame is read back.

// File: rtl/cdb_pkg.sv
// Shared types for the double-banked correlation dump buffer.
package cdb_pkg;

    // State of the dump window in the writer.
    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_e;

endpackage

// File: rtl/cdb_dump_writer.sv
// Dump writer: opens a window on each dump strobe and turns every result
// beat inside the window into a write at {period, index}. The beat whose
// index is all ones closes the window and advances the period count. The
// last beat of the last period produces a one-cycle frame_done.
// Assumes results arrive in ascending index order within a window.
module cdb_dump_writer
    import cdb_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int CYC_W  = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = CYC_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dump_i,
    input  logic              res_valid_i,
    input  logic [IDX_W-1:0]  res_idx_i,
    input  logic [DATA_W-1:0] res_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              frame_done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;
    localparam logic [CYC_W-1:0] LAST_CYC = '1;

    win_state_e       win_q;
    logic [CYC_W-1:0] cyc_q;
    logic             last_beat;

    // Accept a beat only inside an open window.
    always_comb begin
        wr_en_o      = (win_q == WIN_OPEN) && res_valid_i;
        wr_addr_o    = {cyc_q, res_idx_i};
        wr_data_o    = res_data_i;
        last_beat    = wr_en_o && (res_idx_i == LAST_IDX);
        frame_done_o = last_beat && (cyc_q == LAST_CYC);
    end

    // Window state: opened by a strobe, closed by the last-index beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= WIN_CLOSED;
        end else if (win_q == WIN_CLOSED) begin
            if (dump_i) win_q <= WIN_OPEN;
        end else if (last_beat) begin
            win_q <= WIN_CLOSED;
        end
    end

    // Period count: one step per completed dump, wraps at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (last_beat) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

endmodule

// File: rtl/cdb_swap_ctrl.sv
// Swap control: holds which bank is filled, flips it on frame_done, and
// issues the frame pulse. It tracks whether the host released the frame
// it was handed and reports an overrun at the next swap if not.
module cdb_swap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done_i,
    input  logic rd_done_i,
    output logic wr_bank_o,
    output logic frame_ready_o,
    output logic overrun_o
);

    logic wr_bank_q;
    logic ready_q;
    logic overrun_q;
    logic unreleased_q;

    // Bank role: flips only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)            wr_bank_q <= 1'b0;
        else if (frame_done_i) wr_bank_q <= ~wr_bank_q;
    end

    // Frame pulse and overrun pulse, both one cycle after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q   <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            ready_q   <= frame_done_i;
            overrun_q <= frame_done_i && unreleased_q;
        end
    end

    // Release tracking: set by a handover, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)            unreleased_q <= 1'b0;
        else if (frame_done_i) unreleased_q <= 1'b1;
        else if (rd_done_i)    unreleased_q <= 1'b0;
    end

    assign wr_bank_o     = wr_bank_q;
    assign frame_ready_o = ready_q;
    assign overrun_o     = overrun_q;

endmodule

// File: rtl/cdb_bank_pair.sv
// Bank pair: two equal memories. The writer targets wr_bank_i and the host
// reads the other one through a one-cycle registered port. Memory contents
// are not reset.
module cdb_bank_pair #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_bank_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] rd_word [2];
    logic              rd_sel_q;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        // Write port: active only when this bank is the fill bank.
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_bank_i == 1'(g))) mem[wr_addr_i] <= wr_data_i;
        end

        // Registered read of this bank.
        always_ff @(posedge clk) begin
            rd_word[g] <= mem[rd_addr_i];
        end
    end

    // Remember which bank the host owned when the address was sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_sel_q <= 1'b1;
        else        rd_sel_q <= ~wr_bank_i;
    end

    assign rd_data_o = rd_word[rd_sel_q];

endmodule

// File: rtl/corr_dump_buffer.sv
// Top: double-banked dump buffer for correlator results. It connects the
// dump writer, swap control and bank pair. Assumes one result per beat in
// ascending index order, with every window finished before the next strobe.
module corr_dump_buffer #(
    parameter int IDX_W  = 4,
    parameter int CYC_W  = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = CYC_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dump_i,
    input  logic              res_valid_i,
    input  logic [IDX_W-1:0]  res_idx_i,
    input  logic [DATA_W-1:0] res_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_done_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              frame_ready_o,
    output logic              rd_bank_o,
    output logic              overrun_o
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              frame_done;
    logic              wr_bank;

    cdb_dump_writer #(
        .IDX_W (IDX_W),
        .CYC_W (CYC_W),
        .DATA_W(DATA_W)
    ) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .dump_i      (dump_i),
        .res_valid_i (res_valid_i),
        .res_idx_i   (res_idx_i),
        .res_data_i  (res_data_i),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .frame_done_o(frame_done)
    );

    cdb_swap_ctrl u_swap (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done_i (frame_done),
        .rd_done_i    (rd_done_i),
        .wr_bank_o    (wr_bank),
        .frame_ready_o(frame_ready_o),
        .overrun_o    (overrun_o)
    );

    cdb_bank_pair #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_bank_i(wr_bank),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o)
    );

    assign rd_bank_o = ~wr_bank;

endmodule

// File: rtl/cdb_checker.sv
// Checker for corr_dump_buffer: timing properties of the handover outputs.
module cdb_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_ready_o,
    input logic rd_bank_o,
    input logic overrun_o
);

    // R1: the reset values appear at the edge after reset is sampled.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!frame_ready_o && !overrun_o && rd_bank_o));

    // R5: the frame pulse lasts a single cycle.
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready_o |=> !frame_ready_o);

    // R5: the host bank inverts together with the frame pulse.
    p_bank_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready_o |-> (rd_bank_o != $past(rd_bank_o)));

    // R8: the host bank holds whenever there is no frame pulse.
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ready_o |-> $stable(rd_bank_o));

    // R7: an overrun is only ever reported at a handover.
    p_overrun_at_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> frame_ready_o);

endmodule

bind corr_dump_buffer cdb_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_ready_o(frame_ready_o),
    .rd_bank_o    (rd_bank_o),
    .overrun_o    (overrun_o)
);

// File: tb/corr_dump_buffer_tb.sv
// Bench for corr_dump_buffer: random result data with random beat gaps and
// stray beats, plus directed frames, with a concurrent host reader.
module corr_dump_buffer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 4;
    localparam int CYC_W  = 4;
    localparam int DATA_W = 16;
    localparam int ADDR_W = IDX_W + CYC_W;
    localparam int N_IDX  = 1 << IDX_W;
    localparam int N_CYC  = 1 << CYC_W;
    localparam int N_ENT  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dump_i = 1'b0;
    logic              res_valid_i = 1'b0;
    logic [IDX_W-1:0]  res_idx_i = '0;
    logic [DATA_W-1:0] res_data_i = '0;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic              rd_done_i = 1'b0;
    logic [DATA_W-1:0] rd_data_o;
    logic              frame_ready_o;
    logic              rd_bank_o;
    logic              overrun_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DATA_W-1:0] fill_m [N_ENT];
    logic [DATA_W-1:0] host_m [N_ENT];
    logic exp_bank = 1'b1;
    logic exp_unrel = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    corr_dump_buffer #(.IDX_W(IDX_W), .CYC_W(CYC_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .dump_i(dump_i), .res_valid_i(res_valid_i),
        .res_idx_i(res_idx_i), .res_data_i(res_data_i), .rd_addr_i(rd_addr_i),
        .rd_done_i(rd_done_i), .rd_data_o(rd_data_o),
        .frame_ready_o(frame_ready_o), .rd_bank_o(rd_bank_o), .overrun_o(overrun_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected data of a directed or random frame word.
    function automatic logic [DATA_W-1:0] word_for(input int mode, input int addr);
        case (mode)
            1:       return '1;
            2:       return DATA_W'(~addr);
            default: return DATA_W'($urandom);
        endcase
    endfunction

    // One integration period: strobe, then ordered beats with random gaps.
    task automatic do_dump(input int cyc, input int mode, input bit strays);
        @(negedge clk);
        dump_i = 1'b1;
        // R3: a beat alongside the opening strobe must be ignored.
        res_valid_i = strays;
        res_idx_i = IDX_W'(N_IDX - 1);
        res_data_i = 16'hDEAD;
        @(negedge clk);
        dump_i = 1'b0;
        res_valid_i = 1'b0;
        for (int i = 0; i < N_IDX; i++) begin
            int gap;
            gap = int'($urandom_range(0, 2));
            for (int k = 0; k < gap; k++) begin
                res_valid_i = 1'b0;
                // R3: a strobe inside an open window is ignored.
                dump_i = strays && (k == 0);
                @(negedge clk);
                dump_i = 1'b0;
            end
            res_valid_i = 1'b1;
            res_idx_i = IDX_W'(i);
            res_data_i = word_for(mode, cyc * N_IDX + i);
            fill_m[cyc * N_IDX + i] = res_data_i;
            @(negedge clk);
        end
        res_valid_i = 1'b0;
        if (cyc == N_CYC - 1) begin
            check(frame_ready_o == 1'b1, "R5 frame pulse", frame_ready_o, 1);
            check(rd_bank_o == ~exp_bank, "R5 bank swap", rd_bank_o, ~exp_bank);
            check(overrun_o == exp_unrel, "R7 overrun", overrun_o, exp_unrel);
            exp_bank = ~exp_bank;
            exp_unrel = 1'b1;
            for (int a = 0; a < N_ENT; a++) host_m[a] = fill_m[a];
            @(negedge clk);
            check(frame_ready_o == 1'b0, "R5 pulse width", frame_ready_o, 0);
            check(overrun_o == 1'b0, "R7 overrun width", overrun_o, 0);
        end else begin
            check(frame_ready_o == 1'b0, "R4 no early frame", frame_ready_o, 0);
        end
        // R3: stray last-index beat while the window is closed.
        if (strays) begin
            res_valid_i = 1'b1;
            res_idx_i = IDX_W'(N_IDX - 1);
            res_data_i = 16'hBEEF;
            @(negedge clk);
            res_valid_i = 1'b0;
        end
    endtask

    task automatic fill_frame(input int mode, input bit strays);
        for (int c = 0; c < N_CYC; c++) do_dump(c, mode, strays);
    endtask

    // Host reader: walks the whole frame and optionally releases it.
    task automatic read_frame(input bit release_it);
        @(negedge clk);
        rd_addr_i = '0;
        for (int a = 0; a < N_ENT; a++) begin
            @(negedge clk);
            check(rd_data_o == host_m[a], "R2/R6 read data", rd_data_o, host_m[a]);
            rd_addr_i = ADDR_W'(a + 1);
        end
        if (release_it) begin
            rd_done_i = 1'b1;
            @(negedge clk);
            rd_done_i = 1'b0;
            exp_unrel = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(frame_ready_o == 1'b0, "R1 reset frame", frame_ready_o, 0);
        check(overrun_o == 1'b0, "R1 reset overrun", overrun_o, 0);
        check(rd_bank_o == 1'b1, "R1 reset bank", rd_bank_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_bank_o == 1'b1, "R8 bank after reset", rd_bank_o, 1);
        // Frame 0: random data with stray beats; first swap has no overrun (R7).
        fill_frame(0, 1'b1);
        // Frame 1 fills while frame 0 is read and released (R6).
        fork
            fill_frame(1, 1'b0);
            read_frame(1'b1);
        join
        // Frame 2 fills while frame 1 is read but never released: overrun (R7).
        fork
            fill_frame(2, 1'b1);
            read_frame(1'b0);
        join
        // Read back frame 2 to confirm addressing with a directed pattern (R2).
        read_frame(1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule